// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital controller of a serial successive-approximation converter. A chip-select framed transaction moves it through three phases. First comes an acquisition window, in which the input capacitor is sampled and the comparator is zeroed. Next is a bit-by-bit trial search driven by a single comparator bit. Last, the finished code is serialised onto one data pin, most significant bit first. The analog array, the comparator and the reference sit outside the block. The block only drives their switch controls and presents the current trial word to them.

Chip select has two roles. It frames each transaction, and each high period between frames clears the sequencing state. Select may also be raised while a conversion is running. The conversion still finishes, but the result is held until select falls again. After reset the block waits for select to be seen high once before it will start. The first result after reset is flagged as not trustworthy. A power-down input stops all activity at once. After it is released, select must stay high for a configurable number of consecutive clocks before a new frame is accepted.

Top module: `sar_sequencer`

## Requirements
- R1: Each conversion tries bits from the most significant down. At each step the trial bit for that step is set, and it is kept when `cmp_in` is 1 and cleared when it is 0. With a comparator that reports 1 whenever the analog code is at least `trial_bits`, the final `trial_bits` equals the analog code.
- R2: In a frame started from the ready state by `cs_n` falling, `sample_en` and `zero_en` are both high for exactly ACQ_CLKS (4) clocks. After that, `neg_sel` is high with `zero_en` low for exactly W (10) clocks, one per trial step.
- R3: When a conversion ends with `cs_n` low, `data_valid` and `sdo_oe` go high for exactly W clocks. During that window `sdo` carries the result, most significant bit first, one bit per clock.
- R4: Once a result has been shifted out, holding `cs_n` low starts nothing new. `cs_n` must be high for at least one clock before the next acquisition.
- R5: While the sequencer is in its ready state, reached through a `cs_n` high period, `trial_bits` reads all zeros.
- R6: If `cs_n` is raised after acquisition, the conversion still completes and `trial_bits` holds the result. While `cs_n` stays high, `data_valid` and `sdo_oe` stay low. The full result is shifted out, unchanged, once `cs_n` returns low.
- R7: After reset, a low `cs_n` starts no acquisition until `cs_n` has been seen high. `first_conv` is 1 after reset, stays 1 through the shifting of the first result, and is 0 once its last bit has gone out.
- R8: With `pwr_dn` high at a clock edge, `sample_en`, `zero_en`, `neg_sel`, `sdo_oe` and `data_valid` are all 0 from the next clock on. Any conversion in progress is abandoned, and `cs_n` has no effect.
- R9: After `pwr_dn` falls, an acquisition starts only after `cs_n` has been high on REC_CLKS (8) consecutive clocks following the first clock with `pwr_dn` low. A low `cs_n` before that restarts the count.
- R10: Raising `cs_n` during acquisition or during shifting abandons the frame. `data_valid` and `sample_en` then drop at the next clock.
- R11: `sdo` is 0 whenever `sdo_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low chip select, frames transactions |
| pwr_dn | input | 1 | Power-down request, active high |
| cmp_in | input | 1 | Comparator decision for the current trial word |
| sample_en | output | 1 | Connect the positive input to the sampling capacitor |
| zero_en | output | 1 | Close the comparator zeroing switch |
| neg_sel | output | 1 | Switch the sampling capacitor to the negative input |
| trial_bits | output | W | Trial word for the DAC array; the result after conversion |
| sdo | output | 1 | Serial result data |
| sdo_oe | output | 1 | Output enable for `sdo`; low means the pin is released |
| data_valid | output | 1 | High while result bits are on `sdo` |
| first_conv | output | 1 | Marks the first result after reset as invalid |

## Verification
The search is run against an ideal comparator model for several analog codes: all zeros, all ones, the exact midscale code, the code just below midscale, and a mixed pattern. The all-zeros and all-ones codes show that every trial bit is cleared or kept on its own decision. The two codes around midscale separate errors in the most significant step from errors in the lower steps, and the mixed pattern exposes bit-order faults in the serial stream. Frames with select raised at different points (during acquisition, mid-conversion and mid-shift) separate holding a result from abandoning it. The recovery count is probed one clock short of its limit and then at the limit.

// File: rtl/sar_seq_pkg.sv
package sar_seq_pkg;

    typedef enum logic [3:0] {
        PH_WAIT_HI,
        PH_READY,
        PH_ACQ,
        PH_CONV,
        PH_HOLD,
        PH_SHIFT,
        PH_DONE,
        PH_PWRDN,
        PH_RECOVER
    } phase_e;

    // analog switch controls handed to the external array model
    typedef struct packed {
        logic sample;
        logic zero;
        logic neg;
    } ana_ctrl_t;

    // commands from the phase controller to the trial register
    typedef struct packed {
        logic clear;
        logic start;
        logic step;
    } trial_cmd_t;

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic ana_ctrl_t ana_for(input phase_e ph);
        ana_ctrl_t r;
        r = '0;
        case (ph)
            PH_ACQ:  begin r.sample = 1'b1; r.zero = 1'b1; end
            PH_CONV: r.neg = 1'b1;
            default: r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/sar_phase_ctrl.sv
module sar_phase_ctrl
    import sar_seq_pkg::*;
#(
    parameter int W        = 10,
    parameter int ACQ_CLKS = 4,
    parameter int REC_CLKS = 8,
    parameter int CNT_W    = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cs_n,
    input  logic             pwr_dn,
    output phase_e           phase,
    output logic [CNT_W-1:0] cnt,
    output trial_cmd_t       cmd,
    output logic             first_conv
);

    localparam logic [CNT_W-1:0] ACQ_LAST  = CNT_W'(ACQ_CLKS - 1);
    localparam logic [CNT_W-1:0] BIT_LAST  = CNT_W'(W - 1);
    localparam logic [CNT_W-1:0] REC_LAST  = CNT_W'(REC_CLKS - 1);

    phase_e           ph_nx;
    logic [CNT_W-1:0] cnt_nx;
    logic             first_nx;

    always_comb begin
        ph_nx    = phase;
        cnt_nx   = cnt;
        first_nx = first_conv;
        if (pwr_dn) begin
            ph_nx  = PH_PWRDN;
            cnt_nx = '0;
        end else begin
            case (phase)
                PH_WAIT_HI: if (cs_n) ph_nx = PH_READY;
                PH_READY: if (!cs_n) begin
                    ph_nx  = PH_ACQ;
                    cnt_nx = '0;
                end
                PH_ACQ: begin
                    if (cs_n) begin
                        ph_nx = PH_READY;
                    end else if (cnt == ACQ_LAST) begin
                        ph_nx  = PH_CONV;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                PH_CONV: begin
                    if (cnt == BIT_LAST) begin
                        ph_nx  = cs_n ? PH_HOLD : PH_SHIFT;
                        cnt_nx = '0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                PH_HOLD: if (!cs_n) begin
                    ph_nx  = PH_SHIFT;
                    cnt_nx = '0;
                end
                PH_SHIFT: begin
                    if (cs_n) begin
                        ph_nx = PH_READY;
                    end else if (cnt == BIT_LAST) begin
                        ph_nx    = PH_DONE;
                        first_nx = 1'b0;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                PH_DONE: if (cs_n) ph_nx = PH_READY;
                PH_PWRDN: begin
                    ph_nx  = PH_RECOVER;
                    cnt_nx = '0;
                end
                PH_RECOVER: begin
                    if (!cs_n) begin
                        cnt_nx = '0;
                    end else if (cnt == REC_LAST) begin
                        ph_nx = PH_READY;
                    end else begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                default: ph_nx = PH_WAIT_HI;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase      <= PH_WAIT_HI;
            cnt        <= '0;
            first_conv <= 1'b1;
        end else begin
            phase      <= ph_nx;
            cnt        <= cnt_nx;
            first_conv <= first_nx;
        end
    end

    always_comb begin
        cmd.clear = (phase == PH_WAIT_HI) || (phase == PH_READY) ||
                    (phase == PH_PWRDN)   || (phase == PH_RECOVER);
        cmd.start = (phase == PH_ACQ) && !cs_n && !pwr_dn && (cnt == ACQ_LAST);
        cmd.step  = (phase == PH_CONV) && !pwr_dn;
    end

    // R9: a low select during recovery never lets the sequencer reach ready
    p_recover_needs_high_r9: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_RECOVER && !cs_n && !pwr_dn) |=> (phase == PH_RECOVER));

    // R7: the first-result flag only drops at the end of a shift window
    p_first_drop_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(first_conv) |-> ($past(phase) == PH_SHIFT));

endmodule

// File: rtl/sar_trial_reg.sv
module sar_trial_reg
    import sar_seq_pkg::*;
#(
    parameter int W     = 10,
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  trial_cmd_t       cmd,
    input  logic [CNT_W-1:0] cnt,
    input  logic             cmp_in,
    output logic [W-1:0]     trial
);

    // bit under test this step, counted down from the top
    logic [CNT_W-1:0] idx;
    logic [W-1:0]     below;

    assign idx = CNT_W'(W - 1) - cnt;

    always_comb begin
        for (int k = 0; k < W; k++) begin
            below[k] = (CNT_W'(k) < idx);
        end
    end

    always_ff @(posedge clk) begin
        if (rst || cmd.clear) begin
            trial <= '0;
        end else if (cmd.start) begin
            trial <= {1'b1, {(W-1){1'b0}}};
        end else if (cmd.step) begin
            for (int k = 0; k < W; k++) begin
                if (idx == CNT_W'(k)) begin
                    trial[k] <= cmp_in;
                end else if (idx == CNT_W'(k + 1)) begin
                    trial[k] <= 1'b1;
                end
            end
        end
    end

    // R1: every bit below the one under trial is still untouched (zero)
    p_lower_clear_r1: assert property (@(posedge clk) disable iff (rst)
        cmd.step |-> ((trial & below) == '0));

endmodule

// File: rtl/sar_serial_out.sv
module sar_serial_out
    import sar_seq_pkg::*;
#(
    parameter int W     = 10,
    parameter int CNT_W = 4
) (
    input  phase_e           phase,
    input  logic [CNT_W-1:0] cnt,
    input  logic [W-1:0]     trial,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             data_valid
);

    logic [CNT_W-1:0] pos;
    logic             shifting;
    logic             pick;

    assign pos      = CNT_W'(W - 1) - cnt;
    assign shifting = (phase == PH_SHIFT);

    always_comb begin
        pick = 1'b0;
        for (int k = 0; k < W; k++) begin
            if (pos == CNT_W'(k)) pick = trial[k];
        end
    end

    assign sdo        = shifting & pick;
    assign sdo_oe     = shifting;
    assign data_valid = shifting;

endmodule

// File: rtl/sar_sequencer.sv
module sar_sequencer
    import sar_seq_pkg::*;
#(
    parameter int W        = 10,
    parameter int ACQ_CLKS = 4,
    parameter int REC_CLKS = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cs_n,
    input  logic         pwr_dn,
    input  logic         cmp_in,
    output logic         sample_en,
    output logic         zero_en,
    output logic         neg_sel,
    output logic [W-1:0] trial_bits,
    output logic         sdo,
    output logic         sdo_oe,
    output logic         data_valid,
    output logic         first_conv
);

    localparam int CNT_W = $clog2(max3(W, ACQ_CLKS, REC_CLKS) + 1);

    phase_e           phase;
    logic [CNT_W-1:0] cnt;
    trial_cmd_t       cmd;
    ana_ctrl_t        ana;

    sar_phase_ctrl #(
        .W(W), .ACQ_CLKS(ACQ_CLKS), .REC_CLKS(REC_CLKS), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .pwr_dn(pwr_dn),
        .phase(phase), .cnt(cnt), .cmd(cmd), .first_conv(first_conv)
    );

    sar_trial_reg #(.W(W), .CNT_W(CNT_W)) u_trial (
        .clk(clk), .rst(rst), .cmd(cmd), .cnt(cnt),
        .cmp_in(cmp_in), .trial(trial_bits)
    );

    sar_serial_out #(.W(W), .CNT_W(CNT_W)) u_ser (
        .phase(phase), .cnt(cnt), .trial(trial_bits),
        .sdo(sdo), .sdo_oe(sdo_oe), .data_valid(data_valid)
    );

    assign ana       = ana_for(phase);
    assign sample_en = ana.sample;
    assign zero_en   = ana.zero;
    assign neg_sel   = ana.neg;

    // R2: sampling, negative-input switching and shifting never overlap
    p_phase_exclusive_r2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sample_en, neg_sel, data_valid}));

    // R8: power-down silences every control from the next clock
    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        pwr_dn |=> (!sample_en && !zero_en && !neg_sel && !sdo_oe && !data_valid));

    // R6: result bits only appear after select was low at the previous edge
    p_shift_needs_sel_r6: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> !$past(cs_n));

    // R5: ready state shows a cleared trial word one clock after entry
    p_ready_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_READY && $past(phase) == PH_READY) |-> (trial_bits == '0));

    // R11: released pin carries zero
    p_sdo_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !sdo_oe |-> !sdo);

endmodule

// File: tb/sar_sequencer_test.sv
module sar_sequencer_test;
    localparam int W   = 10;
    localparam int ACQ = 4;
    localparam int REC = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         cs_n = 1'b0;
    logic         pwr_dn = 1'b0;
    logic [W-1:0] vin = '0;
    logic         sample_en, zero_en, neg_sel, sdo, sdo_oe, data_valid, first_conv;
    logic [W-1:0] trial_bits;
    logic         cmp_in;

    int checks = 0;
    int fails  = 0;

    // ideal comparator: high when the analog code reaches the trial word
    assign cmp_in = (vin >= trial_bits);

    always #2 clk = ~clk;

    sar_sequencer #(.W(W), .ACQ_CLKS(ACQ), .REC_CLKS(REC)) uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .pwr_dn(pwr_dn), .cmp_in(cmp_in),
        .sample_en(sample_en), .zero_en(zero_en), .neg_sel(neg_sel),
        .trial_bits(trial_bits), .sdo(sdo), .sdo_oe(sdo_oe),
        .data_valid(data_valid), .first_conv(first_conv)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(first_conv == 1'b1, "R7", "first_conv after reset", first_conv, 1);
        chk(trial_bits == '0, "R5", "trial after reset", trial_bits, 0);
        chk(sdo_oe == 1'b0 && sdo == 1'b0, "R11", "sdo idle after reset", sdo, 0);
        begin
            int seen = 0;
            for (int i = 0; i < 8; i++) begin
                @(negedge clk);
                if (sample_en) seen++;
            end
            chk(seen == 0, "R7", "no start before select seen high", seen, 0);
        end
    endtask

    // one full frame: select pulse, then low for long enough to shift and idle
    task automatic t_frame(input logic [W-1:0] v, input bit exp_first);
        int ns = 0, nz = 0, nn = 0, nb = 0, nf = 0, bad = 0;
        logic [W-1:0] got = '0;
        vin = v;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (sample_en) ns++;
            if (zero_en) nz++;
            if (neg_sel) begin
                nn++;
                if (zero_en) bad++;
            end
            if (data_valid) begin
                got = {got[W-2:0], sdo};
                nb++;
                if (first_conv) nf++;
                if (!sdo_oe) bad++;
            end
        end
        chk(ns == ACQ, "R2", "sample cycles", ns, ACQ);
        chk(nz == ACQ, "R2", "zeroing cycles", nz, ACQ);
        chk(nn == W && bad == 0, "R2", "negative-input cycles", nn, W);
        chk(nb == W, "R3", "shifted bit count", nb, W);
        chk(got == v, "R1", "serial result", got, v);
        chk(ns == ACQ, "R4", "no restart with select held low", ns, ACQ);
        chk(nf == (exp_first ? W : 0), "R7", "first flag during shift", nf, exp_first ? W : 0);
        chk(first_conv == 1'b0, "R7", "first flag after frame", first_conv, 0);
    endtask

    task automatic t_hold(input logic [W-1:0] v);
        int nb = 0, leak = 0;
        logic [W-1:0] got = '0;
        vin = v;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        repeat (ACQ + 3) @(negedge clk);
        cs_n = 1'b1;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (data_valid || sdo_oe) leak++;
        end
        chk(leak == 0, "R6", "no output while held", leak, 0);
        chk(trial_bits == v, "R6", "held result", trial_bits, v);
        cs_n = 1'b0;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (data_valid) begin
                got = {got[W-2:0], sdo};
                nb++;
            end
        end
        chk(nb == W && got == v, "R6", "held result shifted", got, v);
    endtask

    task automatic t_abort();
        vin = 10'h15A;
        // abandon during acquisition
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        repeat (2) @(negedge clk);
        chk(sample_en == 1'b1, "R2", "acquisition running", sample_en, 1);
        cs_n = 1'b1;
        @(negedge clk);
        chk(sample_en == 1'b0, "R10", "acquisition abandoned", sample_en, 0);
        repeat (3) @(negedge clk);
        chk(neg_sel == 1'b0, "R10", "no conversion after abandon", neg_sel, 0);
        // abandon during shifting
        cs_n = 1'b0;
        begin
            int guard = 0;
            while (!data_valid && guard < 40) begin
                @(negedge clk);
                guard++;
            end
        end
        repeat (3) @(negedge clk);
        cs_n = 1'b1;
        @(negedge clk);
        chk(data_valid == 1'b0, "R10", "shift abandoned", data_valid, 0);
        @(negedge clk);
        chk(trial_bits == '0, "R5", "trial cleared in ready", trial_bits, 0);
        chk(sdo == 1'b0, "R11", "sdo zero when released", sdo, 0);
    endtask

    task automatic t_power();
        int act = 0;
        vin = 10'h0C3;
        @(negedge clk) cs_n = 1'b1;
        @(negedge clk) cs_n = 1'b0;
        repeat (ACQ + 4) @(negedge clk);
        chk(neg_sel == 1'b1, "R2", "converting before power-down", neg_sel, 1);
        pwr_dn = 1'b1;
        @(negedge clk);
        chk(!sample_en && !zero_en && !neg_sel && !sdo_oe && !data_valid,
            "R8", "controls quiet in power-down", neg_sel, 0);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (sample_en || neg_sel || data_valid) act++;
        end
        chk(act == 0, "R8", "select ignored while powered down", act, 0);
        // one clock short of the recovery count
        pwr_dn = 1'b0;
        cs_n   = 1'b1;
        repeat (REC) @(negedge clk);
        cs_n = 1'b0;
        act  = 0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (sample_en) act++;
        end
        chk(act == 0, "R9", "short recovery rejected", act, 0);
        // full recovery count
        cs_n = 1'b1;
        repeat (REC + 1) @(negedge clk);
        cs_n = 1'b0;
        @(negedge clk);
        chk(sample_en == 1'b1, "R9", "start after full recovery", sample_en, 1);
        repeat (40) @(negedge clk);
    endtask

    initial begin
        t_reset();
        t_frame(10'h2A5, 1'b1);
        t_frame(10'h000, 1'b0);
        t_frame(10'h3FF, 1'b0);
        t_frame(10'h200, 1'b0);
        t_frame(10'h1FF, 1'b0);
        t_hold(10'h36C);
        t_abort();
        t_power();
        t_frame(10'h091, 1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule